// File: doc/BRIEF.md
# Two-Path Priority Interrupt Router

This block gathers interrupt requests from a bank of request nodes and hands each one to one of two service providers: the main processor core or a helper processor that runs peripheral housekeeping. Each node has a pending flag, an enable bit, an 8-bit priority and one target bit. The flag can be raised by a peripheral pulse or by software, and software can clear it. The target bit steers the node to one of two separate arbitration paths.

Each path runs the same state machine in a loop. In `ARB_LOAD` it takes a snapshot of the nodes that are eligible on its target. In `ARB_COUNT` it waits for a round whose length software sets to between 1 and 4 cycles. At the end of the round it picks the highest-priority node that is still eligible. If that priority is above the target's running priority, the path moves to `ARB_PRESENT`. There it raises its request and shows the priority as the vector number. An acknowledge clears the winning node's flag and sends the path back to `ARB_LOAD`. If the winner stops being eligible before it is acknowledged, the request is withdrawn and the path also goes back to `ARB_LOAD`.

The transitions are: `ARB_LOAD` to `ARB_COUNT` always. `ARB_COUNT` to `ARB_PRESENT` when the round ends with a qualifying winner. `ARB_COUNT` to `ARB_LOAD` when the round ends with no qualifying winner. `ARB_PRESENT` to `ARB_LOAD` on acknowledge or on withdrawal.

Top module: `irq_router`

## Requirements
- R1: After reset every pending flag reads 0, both request outputs are low and both vector outputs read 0.
- R2: A node's flag is set by a high `hw_req` or `sw_set` bit and cleared by a high `sw_clr` bit. When a set and a clear hit the same bit in the same cycle, the clear wins. `pend_flags` shows the flags one cycle after the edge that changed them.
- R3: A node takes part in arbitration only while its flag is set, its `node_en` bit is 1 and its priority is non-zero. Any other node is never requested, and its flag is left as it was.
- R4: `node_tgt` bit 0 routes a node to the core path (`core_*`). Bit 1 routes it to the peripheral-processor path (`pcp_*`).
- R5: Among the eligible nodes on one path, the highest priority wins. When priorities tie, the lowest node index wins.
- R6: A path raises its request only when the winner's priority is strictly greater than that path's running-priority input. An equal priority raises nothing.
- R7: While a request is high, its vector equals the winner's priority and holds steady. While the request is low, the vector reads 0.
- R8: The counting phase of a round lasts `round_len`+1 cycles, and one snapshot cycle comes before it. On an idle path, the request rises between `round_len`+2 and 2·`round_len`+4 clock edges after the edge that sets an eligible flag.
- R9: When a path's acknowledge is high while its request is high, the winner's flag clears on that edge, the request is low after it, and a new round begins. No other flag changes.
- R10: If the presented winner stops being eligible (for example through `sw_clr`) before it is acknowledged, the request is low after the next clock edge.
- R11: The two paths run on their own, so both can present requests at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | NODES | Peripheral set pulses, one per node |
| sw_set | input | NODES | Software set, one per node |
| sw_clr | input | NODES | Software clear, one per node (wins over set) |
| node_en | input | NODES | Node enables |
| node_tgt | input | NODES | Target select: 0 = core path, 1 = peripheral-processor path |
| node_prio | input | NODES*PRIO_W | Node priorities; node i occupies bits [i*PRIO_W +: PRIO_W] |
| round_len | input | RLEN_W | Counting-phase length minus one |
| core_run_prio | input | PRIO_W | Running priority of the core |
| pcp_run_prio | input | PRIO_W | Running priority of the peripheral processor |
| core_ack | input | 1 | Core acknowledge |
| pcp_ack | input | 1 | Peripheral-processor acknowledge |
| core_req | output | 1 | Request to the core |
| core_vec | output | PRIO_W | Vector number for the core |
| pcp_req | output | 1 | Request to the peripheral processor |
| pcp_vec | output | PRIO_W | Vector number for the peripheral processor |
| pend_flags | output | NODES | Current pending flags |

## Verification
On every cycle, the assertions check these properties: a newly raised request beats the running priority seen on the edge before; the vector stays fixed while a request is held; an acknowledged request drops on the next edge; an acknowledge or software clear leaves the affected flags at zero; at most one flag is cleared per acknowledge. The bench scenarios are the only place where selection itself is shown to be correct. They cover the highest-priority pick, the tie-break by lowest index, routing by target bit, the enable and zero-priority exclusions, the latency window for each round length, and withdrawal of a request that loses eligibility.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ARB_LOAD    = 2'd0,
        ARB_COUNT   = 2'd1,
        ARB_PRESENT = 2'd2
    } arb_state_e;

    localparam int NUM_TARGETS = 2;
    localparam int TGT_CORE    = 0;
    localparam int TGT_PCP     = 1;

endpackage

// File: rtl/irq_winner_sel.sv
module irq_winner_sel #(
    parameter int NODES  = 8,
    parameter int PRIO_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NODES-1:0]        cand_i,
    input  logic [NODES*PRIO_W-1:0] prio_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic [PRIO_W-1:0]       prio_o
);

    // Strict comparison while scanning upward keeps the lowest index on ties.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NODES; i++) begin
            if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NODES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] set_i,
    input  logic [NODES-1:0] sw_clr_i,
    input  logic [NODES-1:0] ack_clr_a_i,
    input  logic [NODES-1:0] ack_clr_b_i,
    output logic [NODES-1:0] flags_o
);

    logic [NODES-1:0] clr_all;
    logic [NODES-1:0] flags_n;

    assign clr_all = sw_clr_i | ack_clr_a_i | ack_clr_b_i;

    genvar gi;
    generate
        for (gi = 0; gi < NODES; gi++) begin : g_flag
            always_comb begin
                if (clr_all[gi])
                    flags_n[gi] = 1'b0;
                else if (set_i[gi])
                    flags_n[gi] = 1'b1;
                else
                    flags_n[gi] = flags_o[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_o <= '0;
        else
            flags_o <= flags_n;
    end

    // R9: acknowledged nodes read clear after the edge
    p_ack_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_clr_a_i | ack_clr_b_i)) |=>
            ((flags_o & $past(ack_clr_a_i | ack_clr_b_i)) == '0));

    // R2: software clear dominates any simultaneous set
    p_swclr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_clr_i) |=> ((flags_o & $past(sw_clr_i)) == '0));

endmodule

// File: rtl/irq_arb_path.sv
module irq_arb_path
    import irq_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int PRIO_W = 8,
    parameter int RLEN_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODES-1:0]        elig_i,
    input  logic [NODES*PRIO_W-1:0] prio_i,
    input  logic [RLEN_W-1:0]       round_len_i,
    input  logic [PRIO_W-1:0]       run_prio_i,
    input  logic                    ack_i,
    output logic                    req_o,
    output logic [PRIO_W-1:0]       vec_o,
    output logic [NODES-1:0]        clr_o
);

    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    arb_state_e         state;
    arb_state_e         state_n;
    logic [RLEN_W-1:0]  cnt;
    logic [NODES-1:0]   snap;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;

    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic [PRIO_W-1:0]  sel_prio;
    logic               round_end;
    logic               win_alive;

    // Only nodes captured at round start and still eligible now compete.
    irq_winner_sel #(
        .NODES  (NODES),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_sel (
        .cand_i  (snap & elig_i),
        .prio_i  (prio_i),
        .valid_o (sel_valid),
        .idx_o   (sel_idx),
        .prio_o  (sel_prio)
    );

    assign round_end = (state == ARB_COUNT) && (cnt == round_len_i);
    assign win_alive = elig_i[win_idx];

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ARB_LOAD:    state_n = ARB_COUNT;
            ARB_COUNT: begin
                if (round_end) begin
                    if (sel_valid && (sel_prio > run_prio_i))
                        state_n = ARB_PRESENT;
                    else
                        state_n = ARB_LOAD;
                end
            end
            ARB_PRESENT: begin
                if (ack_i || !win_alive)
                    state_n = ARB_LOAD;
            end
            default:     state_n = ARB_LOAD;
        endcase
    end

    // State register and round bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ARB_LOAD;
            cnt      <= '0;
            snap     <= '0;
            win_idx  <= '0;
            win_prio <= '0;
        end else begin
            state <= state_n;
            if (state == ARB_LOAD) begin
                snap <= elig_i;
                cnt  <= '0;
            end
            if (state == ARB_COUNT)
                cnt <= cnt + 1'b1;
            if (round_end && (state_n == ARB_PRESENT)) begin
                win_idx  <= sel_idx;
                win_prio <= sel_prio;
            end
        end
    end

    // Outputs
    always_comb begin
        req_o = (state == ARB_PRESENT);
        vec_o = req_o ? win_prio : '0;
        clr_o = '0;
        if (req_o && ack_i)
            clr_o[win_idx] = 1'b1;
    end

    // R6: a new request only beats the running priority seen at the decision
    p_rise_above_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (vec_o > $past(run_prio_i)));

    // R7: vector held while request held
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o)) |-> $stable(vec_o));

    // R9: acknowledged request drops on the next edge
    p_ack_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    // R9: one node at most is cleared per acknowledge
    p_single_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int PRIO_W = 8,
    parameter int RLEN_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODES-1:0]        hw_req,
    input  logic [NODES-1:0]        sw_set,
    input  logic [NODES-1:0]        sw_clr,
    input  logic [NODES-1:0]        node_en,
    input  logic [NODES-1:0]        node_tgt,
    input  logic [NODES*PRIO_W-1:0] node_prio,
    input  logic [RLEN_W-1:0]       round_len,
    input  logic [PRIO_W-1:0]       core_run_prio,
    input  logic [PRIO_W-1:0]       pcp_run_prio,
    input  logic                    core_ack,
    input  logic                    pcp_ack,
    output logic                    core_req,
    output logic [PRIO_W-1:0]       core_vec,
    output logic                    pcp_req,
    output logic [PRIO_W-1:0]       pcp_vec,
    output logic [NODES-1:0]        pend_flags
);

    logic [NODES-1:0]  elig;
    logic [NODES-1:0]  path_elig [NUM_TARGETS];
    logic [PRIO_W-1:0] path_run  [NUM_TARGETS];
    logic              path_ack  [NUM_TARGETS];
    logic              path_req  [NUM_TARGETS];
    logic [PRIO_W-1:0] path_vec  [NUM_TARGETS];
    logic [NODES-1:0]  path_clr  [NUM_TARGETS];

    irq_flag_bank #(
        .NODES (NODES)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (hw_req | sw_set),
        .sw_clr_i    (sw_clr),
        .ack_clr_a_i (path_clr[TGT_CORE]),
        .ack_clr_b_i (path_clr[TGT_PCP]),
        .flags_o     (pend_flags)
    );

    genvar gn;
    generate
        for (gn = 0; gn < NODES; gn++) begin : g_elig
            assign elig[gn] = pend_flags[gn] & node_en[gn]
                            & (|node_prio[gn*PRIO_W +: PRIO_W]);
        end
    endgenerate

    assign path_elig[TGT_CORE] = elig & ~node_tgt;
    assign path_elig[TGT_PCP]  = elig &  node_tgt;
    assign path_run[TGT_CORE]  = core_run_prio;
    assign path_run[TGT_PCP]   = pcp_run_prio;
    assign path_ack[TGT_CORE]  = core_ack;
    assign path_ack[TGT_PCP]   = pcp_ack;

    genvar gt;
    generate
        for (gt = 0; gt < NUM_TARGETS; gt++) begin : g_path
            irq_arb_path #(
                .NODES  (NODES),
                .PRIO_W (PRIO_W),
                .RLEN_W (RLEN_W)
            ) u_path (
                .clk         (clk),
                .rst_n       (rst_n),
                .elig_i      (path_elig[gt]),
                .prio_i      (node_prio),
                .round_len_i (round_len),
                .run_prio_i  (path_run[gt]),
                .ack_i       (path_ack[gt]),
                .req_o       (path_req[gt]),
                .vec_o       (path_vec[gt]),
                .clr_o       (path_clr[gt])
            );
        end
    endgenerate

    assign core_req = path_req[TGT_CORE];
    assign core_vec = path_vec[TGT_CORE];
    assign pcp_req  = path_req[TGT_PCP];
    assign pcp_vec  = path_vec[TGT_PCP];

    // R3: a raised request never carries the reserved priority 0
    p_vec_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req |-> (core_vec != '0)) and (pcp_req |-> (pcp_vec != '0)));

    // R4: the two paths never clear the same node together
    p_paths_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((path_clr[TGT_CORE] & path_clr[TGT_PCP]) == '0));

endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

    localparam int N  = 8;
    localparam int PW = 8;
    localparam int RW = 2;
    localparam int NV = 10;
    localparam int VW = 122;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    hw_req = '0, sw_set = '0, sw_clr = '0;
    logic [N-1:0]    node_en = '0, node_tgt = '0;
    logic [N*PW-1:0] node_prio = '0;
    logic [RW-1:0]   round_len = '0;
    logic [PW-1:0]   core_run_prio = '0, pcp_run_prio = '0;
    logic            core_ack = 1'b0, pcp_ack = 1'b0;
    logic            core_req, pcp_req;
    logic [PW-1:0]   core_vec, pcp_vec;
    logic [N-1:0]    pend_flags;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_router #(.NODES(N), .PRIO_W(PW), .RLEN_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set),
        .sw_clr(sw_clr), .node_en(node_en), .node_tgt(node_tgt),
        .node_prio(node_prio), .round_len(round_len),
        .core_run_prio(core_run_prio), .pcp_run_prio(pcp_run_prio),
        .core_ack(core_ack), .pcp_ack(pcp_ack), .core_req(core_req),
        .core_vec(core_vec), .pcp_req(pcp_req), .pcp_vec(pcp_vec),
        .pend_flags(pend_flags)
    );

    // {en, tgt, prio[7..0], core_run, pcp_run,
    //  core_req, core_vec, core_idx, pcp_req, pcp_vec, pcp_idx}
    localparam logic [VW-1:0] VEC [NV] = '{
        // R5 highest wins
        {8'hFF, 8'h00, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd30,8'd50,8'd10}, 8'd0, 8'd0,
         1'b1, 8'd50, 4'd1, 1'b0, 8'd0, 4'd15},
        // R5 tie, lower index
        {8'hFF, 8'h00, {8'd0,8'd0,8'd40,8'd0,8'd0,8'd40,8'd0,8'd0}, 8'd0, 8'd0,
         1'b1, 8'd40, 4'd2, 1'b0, 8'd0, 4'd15},
        // R4 R11 split routing
        {8'hFF, 8'hF0, {8'd0,8'd100,8'd0,8'd200,8'd9,8'd0,8'd0,8'd5}, 8'd0, 8'd0,
         1'b1, 8'd9, 4'd3, 1'b1, 8'd200, 4'd4},
        // R3 disabled node skipped
        {8'hFD, 8'h00, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd20,8'd90,8'd0}, 8'd0, 8'd0,
         1'b1, 8'd20, 4'd2, 1'b0, 8'd0, 4'd15},
        // R6 equal running priority blocks
        {8'hFF, 8'h00, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd60}, 8'd60, 8'd0,
         1'b0, 8'd0, 4'd15, 1'b0, 8'd0, 4'd15},
        // R6 one below passes
        {8'hFF, 8'h00, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd60}, 8'd59, 8'd0,
         1'b1, 8'd60, 4'd0, 1'b0, 8'd0, 4'd15},
        // R3 all zero priority
        {8'hFF, 8'h00, 64'd0, 8'd0, 8'd0,
         1'b0, 8'd0, 4'd15, 1'b0, 8'd0, 4'd15},
        // R5 top level on the helper path
        {8'hFF, 8'hFF, {8'd255,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0}, 8'd0, 8'd254,
         1'b0, 8'd0, 4'd15, 1'b1, 8'd255, 4'd7},
        // R5 tie on the helper path
        {8'hFF, 8'hFF, {8'd0,8'd7,8'd0,8'd7,8'd0,8'd0,8'd0,8'd0}, 8'd0, 8'd0,
         1'b0, 8'd0, 4'd15, 1'b1, 8'd7, 4'd4},
        // R6 R11 per-path running priority
        {8'hFF, 8'hF0, {8'd0,8'd0,8'd0,8'd80,8'd0,8'd0,8'd0,8'd70}, 8'd0, 8'd80,
         1'b1, 8'd70, 4'd0, 1'b0, 8'd0, 4'd15}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        sw_clr = '1;
        cyc(1);
        sw_clr = '0;
        cyc(4);
    endtask

    task automatic latency_run(input int len);
        int k;
        round_len = RW'(len);
        cyc(12);
        sw_set = 8'h01;
        cyc(1);
        sw_set = '0;
        k = 0;
        while (k < 30) begin
            cyc(1);
            k++;
            if (core_req) break;
        end
        chk_rng("R8 latency", k, len + 2, 2 * len + 4);
        chk("R7 vec", 32'(core_vec), 32'd5);
        core_ack = 1'b1;
        cyc(1);
        core_ack = 1'b0;
        chk("R9 req drop", 32'(core_req), 32'd0);
        chk("R9 flag clr", 32'(pend_flags), 32'd0);
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [N-1:0]  exp_fl;
        cyc(3);
        // R1 reset state
        chk("R1 flags", 32'(pend_flags), 32'd0);
        chk("R1 core_req", 32'(core_req), 32'd0);
        chk("R1 pcp_req", 32'(pcp_req), 32'd0);
        chk("R1 vecs", 32'({core_vec, pcp_vec}), 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R2 flag set/clear, nodes disabled
        hw_req = 8'h04;
        cyc(1);
        hw_req = '0;
        chk("R2 hw set", 32'(pend_flags), 32'h04);
        sw_set = 8'h08; sw_clr = 8'h08;
        cyc(1);
        sw_set = '0; sw_clr = '0;
        chk("R2 clr wins", 32'(pend_flags), 32'h04);
        hw_req = 8'h04; sw_clr = 8'h04;
        cyc(1);
        hw_req = '0; sw_clr = '0;
        chk("R2 clr over hw", 32'(pend_flags), 32'h00);
        chk("R3 disabled no req", 32'({core_req, pcp_req}), 32'd0);

        // Table-driven arbitration
        round_len = 2'd1;
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            node_en       = v[121:114];
            node_tgt      = v[113:106];
            node_prio     = v[105:42];
            core_run_prio = v[41:34];
            pcp_run_prio  = v[33:26];
            cyc(1);
            sw_set = '1;
            cyc(1);
            sw_set = '0;
            cyc(16);
            chk($sformatf("R5 v%0d core_req", i), 32'(core_req), 32'(v[25]));
            chk($sformatf("R7 v%0d core_vec", i), 32'(core_vec), 32'(v[24:17]));
            chk($sformatf("R4 v%0d pcp_req", i), 32'(pcp_req), 32'(v[12]));
            chk($sformatf("R7 v%0d pcp_vec", i), 32'(pcp_vec), 32'(v[11:4]));
            exp_fl = '1;
            if (v[25]) exp_fl[v[16:13]] = 1'b0;
            if (v[12]) exp_fl[v[3:0]]   = 1'b0;
            core_ack = v[25];
            pcp_ack  = v[12];
            cyc(1);
            core_ack = 1'b0;
            pcp_ack  = 1'b0;
            chk($sformatf("R9 v%0d flags", i), 32'(pend_flags), 32'(exp_fl));
            chk($sformatf("R9 v%0d reqs low", i), 32'({core_req, pcp_req}), 32'd0);
            clear_all();
        end

        // R8 round length and R9 acknowledge
        node_en = 8'h01; node_tgt = '0;
        node_prio = 64'd5;
        core_run_prio = '0; pcp_run_prio = '0;
        latency_run(0);
        latency_run(3);

        // R10 withdrawal on software clear
        round_len = 2'd3;
        sw_set = 8'h01;
        cyc(1);
        sw_set = '0;
        cyc(14);
        chk("R10 req before", 32'(core_req), 32'd1);
        sw_clr = 8'h01;
        cyc(1);
        sw_clr = '0;
        cyc(1);
        chk("R10 withdrawn", 32'(core_req), 32'd0);
        chk("R10 vec zero", 32'(core_vec), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule